// File: doc/BRIEF.md
# Mailbox I2C Master

This block is an I2C bus master that a host processor runs through a small set of 16-bit registers. The host loads up to two bytes of outgoing data, then writes a command word that names a 7-bit target, a direction and a byte count. The block then performs one bus transaction: a START, the address byte, and one or two data bytes. When the transaction ends it raises a completion flag: one for transmit, one for receive, or an error flag when a target refuses a byte.

Each command carries a hold flag. When the flag is set, the block issues no STOP. It keeps SCL low so that the bus stays claimed, and the next command opens with a repeated START. A host uses this to write a register offset in one command and then read or write the data in a following one, as a single bus transaction. Open-drain pads attach to the two drive-low enables, and the SDA pad input feeds back in. The SCL rate comes from a divider that the host sets. An interrupt line combines the event flags that the host has enabled.

Top module: `mbox_i2c_master`

## Requirements
- R1: After reset the status, read-data and data mailbox registers read 0, the control register reads the divider reset value (4) with all enables clear, both drive-low enables are 0, and irq is 0.
- R2: Register offsets are 0x0 status, 0x2 control, 0x4 outgoing data, 0x6 command, 0x8 received data. Control bits 15:13 are the interrupt enables and bits 7:0 the divider. Both control and outgoing data read back as written.
- R3: A write command (bit 10 = 1) sends START, then the address byte {addr, 0}, then outgoing-data bits 7:0 and, when bit 11 is set, bits 15:8. On success it sets status bit 14.
- R4: A read command (bit 10 = 0) sends the address byte {addr, 1}. The first byte received lands in read-data bits 7:0 and the second in bits 15:8. Bits 15:8 read 0 after a one-byte read. On success it sets status bit 15.
- R5: During a read the master ACKs every byte except the last byte of a command with hold clear, which it NACKs.
- R6: With hold (bit 13) clear a command ends with STOP and releases both lines. With hold set no STOP is sent, SCL stays driven low while idle, and the next command begins with a START condition (a repeated START).
- R7: A NACK on the address byte or on a written byte stops the byte sequence, sends STOP, frees the bus and sets status bit 13, not the transmit or receive flag.
- R8: Writing 1 to status bits 15:13 clears those flags. If a flag is set in the same cycle that it is cleared, the set wins.
- R9: Status bit 0 reads 1 while a command is in progress. A command written during that time is discarded and never reaches the bus.
- R10: A command whose bits 15:14 are not 2'b10 is discarded: no bus activity and no event.
- R11: irq is 1 exactly when some status bit among 15:13 is set together with the control bit at the same position.
- R12: Each SCL high phase during a byte lasts 2*(div+1) clock cycles, where div is control bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt, OR of enabled event flags |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA pad level |

## Verification
Two functions can fall in the same clock edge: a host write that clears status flags, and a completing transaction that sets one. The bench writes the clear pattern to the status register on every cycle while the busy bit reads 1. It stops on the first cycle that busy reads 0, so the last clear write lands on exactly the edge that sets the transmit flag. The transmit flag must then read 1, and a later plain clear must remove it.

// File: rtl/mbox_i2c_master.sv
module mbox_i2c_master #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int PADW = 13 - DIV_W;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} st_t;
  st_t state;

  logic [2:0]       ev, en, ev_set, ev_clr;
  logic [DIV_W-1:0] div, cnt;
  logic [15:0]      wbuf, rbuf, txd;
  logic [6:0]       cmd_addr;
  logic             cmd_wr, cmd_two, cmd_hold, claimed, abort, nack;
  logic [1:0]       q, byten;
  logic [3:0]       bitn;
  logic [7:0]       shreg;
  logic             busy, tick, cmd_go, rx_byte, last_byte, fin_hold, fin_stop, fin;

  assign busy      = state != S_IDLE;
  assign tick      = busy && cnt == div;
  assign cmd_go    = reg_wr && reg_addr == 4'h6 && !busy && reg_wdata[15:14] == 2'b10;
  assign rx_byte   = byten != 2'd0 && !cmd_wr;
  assign last_byte = byten == (cmd_two ? 2'd2 : 2'd1);
  assign fin_hold  = tick && q == 2'd3 && state == S_BYTE && bitn == 4'd8 && last_byte
                     && !(!rx_byte && nack) && cmd_hold;
  assign fin_stop  = tick && q == 2'd3 && state == S_STOP;
  assign fin       = fin_hold || fin_stop;
  assign ev_set    = !fin ? 3'b000 : abort ? 3'b001 : cmd_wr ? 3'b010 : 3'b100;
  assign ev_clr    = (reg_wr && reg_addr == 4'h0) ? reg_wdata[15:13] : 3'b000;
  assign irq       = |(ev & en);

  always_comb begin
    case (reg_addr)
      4'h0:    reg_rdata = {ev, 12'h000, busy};
      4'h2:    reg_rdata = {en, {PADW{1'b0}}, div};
      4'h4:    reg_rdata = wbuf;
      4'h8:    reg_rdata = rbuf;
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state)
      S_IDLE:  scl_oe = claimed;
      S_START: begin
        scl_oe = q[1];
        sda_oe = q != 2'd0;
      end
      S_BYTE: begin
        scl_oe = q == 2'd0 || q == 2'd3;
        if (bitn == 4'd8) sda_oe = rx_byte && !(last_byte && !cmd_hold);
        else              sda_oe = !rx_byte && !shreg[7];
      end
      S_STOP: begin
        scl_oe = q == 2'd0;
        sda_oe = q < 2'd2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ev       <= '0;
      en       <= '0;
      div      <= DIV_W'(DIV_RESET);
      cnt      <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      txd      <= '0;
      cmd_addr <= '0;
      cmd_wr   <= 1'b0;
      cmd_two  <= 1'b0;
      cmd_hold <= 1'b0;
      claimed  <= 1'b0;
      abort    <= 1'b0;
      nack     <= 1'b0;
      q        <= '0;
      byten    <= '0;
      bitn     <= '0;
      shreg    <= '0;
    end else begin
      if (reg_wr && reg_addr == 4'h2) begin
        en  <= reg_wdata[15:13];
        div <= reg_wdata[DIV_W-1:0];
      end
      if (reg_wr && reg_addr == 4'h4) wbuf <= reg_wdata;
      ev  <= (ev & ~ev_clr) | ev_set;
      cnt <= (!busy || tick) ? '0 : cnt + DIV_W'(1);

      if (cmd_go) begin
        state    <= S_START;
        q        <= '0;
        cmd_addr <= reg_wdata[7:1];
        cmd_wr   <= reg_wdata[10];
        cmd_two  <= reg_wdata[11];
        cmd_hold <= reg_wdata[13];
        txd      <= wbuf;
        abort    <= 1'b0;
        if (!reg_wdata[10]) rbuf <= '0;
      end else if (tick) begin
        q <= q + 2'd1;
        if (q == 2'd2 && state == S_BYTE) begin
          if (bitn == 4'd8) nack  <= sda_in;
          else if (rx_byte) shreg <= {shreg[6:0], sda_in};
        end
        if (q == 2'd3) begin
          case (state)
            S_START: begin
              state <= S_BYTE;
              bitn  <= '0;
              byten <= '0;
              shreg <= {cmd_addr, !cmd_wr};
            end
            S_BYTE: begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1;
                if (!rx_byte) shreg <= {shreg[6:0], 1'b0};
              end else begin
                if (rx_byte) begin
                  if (byten == 2'd1) rbuf[7:0]  <= shreg;
                  else               rbuf[15:8] <= shreg;
                end
                if (!rx_byte && nack) begin
                  abort <= 1'b1;
                  state <= S_STOP;
                end else if (last_byte) begin
                  if (cmd_hold) begin
                    state   <= S_IDLE;
                    claimed <= 1'b1;
                  end else begin
                    state <= S_STOP;
                  end
                end else begin
                  byten <= byten + 2'd1;
                  bitn  <= '0;
                  shreg <= (byten == 2'd0) ? txd[7:0] : txd[15:8];
                end
              end
            end
            S_STOP: begin
              state   <= S_IDLE;
              claimed <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mbox_i2c_master_chk.sv
module mbox_i2c_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        busy,
  input logic        claimed,
  input logic [2:0]  ev,
  input logic [6:0]  cmd_addr,
  input logic [1:0]  state
);
  // R9
  cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 4'h6) |=> $stable(cmd_addr));

  // R10
  mode_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == 4'h6 && reg_wdata[15:14] != 2'b10) |=> !busy);

  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ev != 3'b000));

  // R6
  held_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && claimed) |-> scl_oe);

  // R6
  bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !claimed) |-> (!scl_oe && !sda_oe));

  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !scl_oe && $past(state == 2'd2 && !scl_oe)) |-> $stable(sda_oe));
endmodule

bind mbox_i2c_master mbox_i2c_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .claimed(claimed), .ev(ev),
  .cmd_addr(cmd_addr), .state(state)
);

// File: tb/tb_mbox_i2c_master.sv
module tb_mbox_i2c_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq, scl_oe, sda_oe;
  logic        s_drv = 1'b0;
  wire         scl = ~scl_oe;
  wire         sda = ~(sda_oe | s_drv);

  mbox_i2c_master #(.DIV_W(8), .DIV_RESET(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
  );

  localparam logic [6:0]  SLV = 7'h50;
  localparam logic [11:0] IT_START = 12'h800;
  localparam logic [11:0] IT_STOP  = 12'h400;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [11:0] expq[$];
  logic [15:0] exp_status, exp_rdata;
  logic [7:0]  rd_model = 8'hC3;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic got(logic [11:0] it);
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL %s bus item actual=%h expected=none", cur_req, it);
    end else begin
      logic [11:0] e;
      e = expq.pop_front();
      if (e !== it) begin
        fails++;
        $display("FAIL %s bus item actual=%h expected=%h", cur_req, it, e);
      end
    end
  endtask

  // target model and bus monitor
  logic pscl = 1'b1, psda = 1'b1, ackb = 1'b0, rdir = 1'b0;
  logic [7:0] shr = 8'h0, txb = 8'h0, rd_next = 8'hC3;
  int bitc = 0, ph = 0, hi_run = 0, last_hi = 0;

  always @(negedge clk) begin
    logic cs, cd;
    cs = scl;
    cd = sda;
    if (cs && pscl && psda && !cd) begin
      got(IT_START); ph = 1; bitc = 0; s_drv = 1'b0;
    end else if (cs && pscl && !psda && cd) begin
      got(IT_STOP); ph = 0; s_drv = 1'b0;
    end else if (cs && !pscl) begin
      if (ph != 0) begin
        if (bitc < 8) shr = {shr[6:0], cd};
        else ackb = cd;
        bitc++;
      end
    end else if (!cs && pscl && ph != 0) begin
      if (bitc == 8) begin
        if (ph == 1) begin rdir = shr[0]; s_drv = (shr[7:1] == SLV); end
        else if (ph == 2) s_drv = (shr != 8'hFF);
        else s_drv = 1'b0;
      end else if (bitc == 9) begin
        got({3'b000, ackb, shr});
        s_drv = 1'b0;
        bitc = 0;
        if (ph == 1) ph = ackb ? 0 : (rdir ? 3 : 2);
        else if (ph == 2) ph = ackb ? 0 : 2;
        else ph = ackb ? 0 : 3;
        if (ph == 3) begin
          txb = rd_next; rd_next = rd_next + 8'd1; s_drv = ~txb[7];
        end
      end else if (ph == 3 && bitc < 8) begin
        s_drv = ~txb[7-bitc];
      end
    end
    if (cs) hi_run++;
    else begin
      if (pscl) last_hi = hi_run;
      hi_run = 0;
    end
    pscl = cs;
    psda = ~(sda_oe | s_drv);
  end

  task automatic reg_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin
      @(negedge clk);
      reg_addr = 4'h0;
      #1 n++;
    end while (reg_rdata[0] && n < 20000);
  endtask

  task automatic send(string req, logic [6:0] a, bit wr, bit two, bit hold, logic [15:0] d);
    bit ok, nk;
    logic [7:0] b;
    int n;
    cur_req = req;
    exp_rdata = 16'h0;
    ok = (a == SLV);
    expq.push_back(IT_START);
    expq.push_back({3'b000, !ok, a, !wr});
    n = two ? 2 : 1;
    for (int i = 0; i < n && ok; i++) begin
      if (wr) begin
        b = (i != 0) ? d[15:8] : d[7:0];
        nk = (b == 8'hFF);
        expq.push_back({3'b000, nk, b});
        if (nk) ok = 0;
      end else begin
        b = rd_model; rd_model = rd_model + 8'd1;
        nk = (i == n - 1) && !hold;
        expq.push_back({3'b000, nk, b});
        if (i != 0) exp_rdata[15:8] = b; else exp_rdata[7:0] = b;
      end
    end
    if (!ok || !hold) expq.push_back(IT_STOP);
    exp_status = !ok ? 16'h2000 : wr ? 16'h4000 : 16'h8000;
    if (wr) reg_write(4'h4, d);
    reg_write(4'h6, {2'b10, hold, 1'b0, two, wr, 2'b00, a, 1'b0});
  endtask

  task automatic post(string req);
    logic [15:0] v;
    reg_read(4'h0, v);
    chk({req, " status"}, v, exp_status);
    chk({req, " bus items left"}, expq.size(), 0);
  endtask

  task automatic clear_ev(string req);
    logic [15:0] v;
    reg_write(4'h0, 16'hE000);
    reg_read(4'h0, v);
    chk({req, " flags cleared"}, v, 16'h0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    reg_read(4'h0, v); chk("R1 status", v, 16'h0);
    reg_read(4'h8, v); chk("R1 rdata", v, 16'h0);
    reg_read(4'h4, v); chk("R1 wdata", v, 16'h0);
    reg_read(4'h2, v); chk("R1 ctrl", v, 16'h0004);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);

    reg_write(4'h2, 16'hE001);
    reg_read(4'h2, v); chk("R2 ctrl readback", v, 16'hE001);
    reg_write(4'h4, 16'hBEEF);
    reg_read(4'h4, v); chk("R2 data mailbox readback", v, 16'hBEEF);

    // R3 two-byte write
    send("R3", SLV, 1, 1, 0, 16'h3412);
    wait_idle(); post("R3");
    chk("R11 irq on tx", irq, 1);
    chk("R12 scl high div=1", last_hi, 4);
    chk("R6 bus released after stop", {scl_oe, sda_oe}, 0);
    clear_ev("R8");
    chk("R11 irq after clear", irq, 0);

    // R6 held offset write then R4/R5 two-byte read
    send("R6", SLV, 1, 0, 1, 16'h0007);
    wait_idle(); post("R6");
    repeat (20) @(negedge clk);
    chk("R6 scl held low", scl_oe, 1);
    chk("R6 no stop while held", expq.size(), 0);
    clear_ev("R6");
    send("R4", SLV, 0, 1, 0, 16'h0);
    wait_idle(); post("R5");
    reg_read(4'h8, v); chk("R4 two-byte read data", v, exp_rdata);
    clear_ev("R4");

    // R4 one-byte read
    send("R4", SLV, 0, 0, 0, 16'h0);
    wait_idle(); post("R4");
    reg_read(4'h8, v); chk("R4 one-byte read data", v, exp_rdata);
    clear_ev("R4");

    // R7 address NACK and data NACK
    send("R7", 7'h33, 1, 1, 0, 16'h5566);
    wait_idle(); post("R7");
    chk("R7 bus freed", {scl_oe, sda_oe}, 0);
    clear_ev("R7");
    send("R7", SLV, 1, 1, 0, 16'h22FF);
    wait_idle(); post("R7");
    clear_ev("R7");

    // R9 command while busy
    send("R9", SLV, 1, 0, 0, 16'h0011);
    reg_read(4'h0, v); chk("R9 busy bit", v[0], 1);
    reg_write(4'h6, {2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, SLV, 1'b0});
    wait_idle(); post("R9");
    repeat (100) @(negedge clk);
    chk("R9 no second transfer", {scl_oe, sda_oe, 30'(expq.size())}, 0);
    clear_ev("R9");

    // R10 wrong mode field
    cur_req = "R10";
    reg_write(4'h6, {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, SLV, 1'b0});
    reg_read(4'h0, v); chk("R10 not busy", v, 16'h0);
    repeat (50) @(negedge clk);
    reg_read(4'h0, v); chk("R10 no event", v, 16'h0);
    chk("R10 bus idle", {scl_oe, sda_oe}, 0);

    // R11 masking
    reg_write(4'h2, 16'h0001);
    send("R11", SLV, 1, 0, 0, 16'h0042);
    wait_idle(); post("R11");
    chk("R11 masked irq", irq, 0);
    reg_write(4'h2, 16'h4001); #1 chk("R11 tx enabled irq", irq, 1);
    reg_write(4'h2, 16'h8001); #1 chk("R11 other enable irq", irq, 0);
    reg_write(4'h2, 16'hE001);
    clear_ev("R11");

    // R8 clear collides with the completing set
    send("R8", SLV, 1, 0, 0, 16'h0055);
    reg_addr = 4'h0; reg_wdata = 16'hE000;
    forever begin
      #1;
      if (!reg_rdata[0]) break;
      reg_wr = 1'b1;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    #1 chk("R8 set wins over clear", reg_rdata, 16'h4000);
    chk("R8 bus items left", expq.size(), 0);
    clear_ev("R8");

    // R12 slower divider
    reg_write(4'h2, 16'hE003);
    send("R12", SLV, 1, 0, 0, 16'h0099);
    wait_idle(); post("R12");
    chk("R12 scl high div=3", last_hi, 8);
    reg_write(4'h2, 16'hE001);
    clear_ev("R12");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule